// File: doc/BRIEF.md
# Tick Compare Timer

This block keeps a free-running cycle counter next to a compare register and raises a one-cycle match pulse when the counter arrives at the programmed compare value. The pulse is meant to set the timer bit of a software-interrupt register outside the block. The counter advances once per cycle in which the enable tick is high. Clock-rate scaling is left to whatever generates that tick.

Each of the two 64-bit registers carries a flag in its top bit. In the count register that bit is a privileged-read flag. In the compare register it is an interrupt-disable flag. Writes split each word into the flag and a 63-bit value, and reads put the two back together. The compare value arms the timer only when it is nonzero and its disable flag is clear. An armed compare produces exactly one match. A compare value that the counter has already reached when it is written fires on the next tick rather than waiting for the counter to wrap.

Top module: `tick_cmp_timer`

## Requirements
- R1: A count write loads wr_data[62:0] into the counter and wr_data[63] into the privileged-read flag; the new value appears on cnt_rd_data in the cycle after the write.
- R2: cnt_rd_data[63] equals the privileged-read flag and cnt_rd_data[62:0] equals the counter value.
- R3: A limit write stores wr_data[63] as the disable flag and wr_data[62:0] as the compare value, and lim_rd_data returns exactly the written word in the cycle after the write.
- R4: A compare value of zero never produces a match.
- R5: When the disable flag is set, no match is produced.
- R6: When the armed timer sees a tick that makes the counter equal the compare value, match_pulse is high for the one cycle that follows that tick.
- R7: If the compare value is less than or equal to the counter at the time of the limit write, the match comes after the first tick that follows the write.
- R8: A synchronous reset sets the counter to zero, sets both flags to 1, clears the compare value, cancels any armed compare and holds match_pulse low. Both read ports return 64'h8000_0000_0000_0000 after reset.
- R9: Each limit write produces at most one match. The timer re-arms only on a new limit write.
- R10: The counter increments by one on each tick and wraps from 2^63-1 to 0. A count write in the same cycle as a tick takes priority over the increment. A limit write in the same cycle as a tick takes priority over a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the counter by one this cycle |
| cnt_wr | input | 1 | Write wr_data into the count register |
| lim_wr | input | 1 | Write wr_data into the limit register |
| wr_data | input | 64 | Write word; bit 63 is the flag, bits 62:0 the value |
| cnt_rd_data | output | 64 | Count register read: flag in bit 63, counter below |
| lim_rd_data | output | 64 | Limit register read: disable flag in bit 63, compare value below |
| match_pulse | output | 1 | One-cycle pulse when the armed compare is reached |

## Verification
Some properties are checked on every cycle. Writes to either register read back one cycle later. The counter holds or steps by exactly one. A match never appears while the limit is zero or disabled, never lasts two cycles and always follows a tick. The state after reset is checked as well.

Other behaviour spans whole sequences and is shown only by the bench's scenarios. These are the exact cycle of a match after several ticks, the immediate firing of a limit that is already behind, the silence after the first match, and the wrap at 2^63.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    parameter int unsigned TT_WORD_W = 64;
    localparam int unsigned TT_VAL_W = TT_WORD_W - 1;

    typedef logic [TT_VAL_W-1:0]  tt_val_t;
    typedef logic [TT_WORD_W-1:0] tt_word_t;

    // A register word: top flag plus the value beneath it
    typedef struct packed {
        logic    flag;
        tt_val_t val;
    } tt_reg_t;

    localparam tt_reg_t TT_RESET_REG = '{flag: 1'b1, val: '0};

    function automatic tt_reg_t tt_split(input tt_word_t w);
        return tt_reg_t'(w);
    endfunction

    function automatic tt_word_t tt_join(input tt_reg_t r);
        return tt_word_t'(r);
    endfunction

    function automatic tt_val_t tt_incr(input tt_val_t v);
        return v + tt_val_t'(1);
    endfunction
endpackage

// File: rtl/tt_counter.sv
module tt_counter
    import tick_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_en,
    input  logic    load,
    input  tt_reg_t load_word,
    output tt_reg_t cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= TT_RESET_REG;
        end else if (load) begin
            cnt_q <= load_word;
        end else if (tick_en) begin
            cnt_q.val <= tt_incr(cnt_q.val);
        end
    end
endmodule

// File: rtl/tt_limit.sv
module tt_limit
    import tick_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  tt_reg_t wr_word,
    input  tt_val_t cur_val,
    input  logic    consume,
    output tt_reg_t lim_q,
    output logic    armed,
    output logic    late
);
    logic arm_ok;
    assign arm_ok = !wr_word.flag && (wr_word.val != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '{flag: 1'b1, val: '0};
            armed <= 1'b0;
            late  <= 1'b0;
        end else if (wr) begin
            lim_q <= wr_word;
            armed <= arm_ok;
            late  <= (wr_word.val <= cur_val);
        end else if (consume) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/tt_match.sv
module tt_match
    import tick_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_en,
    input  logic    suppress,
    input  logic    armed,
    input  logic    late,
    input  tt_val_t cnt_val,
    input  tt_val_t lim_val,
    output logic    hit,
    output logic    match_q
);
    tt_val_t nxt_val;
    assign nxt_val = tt_incr(cnt_val);
    assign hit = armed && tick_en && !suppress && (late || (nxt_val == lim_val));

    always_ff @(posedge clk) begin
        if (rst) match_q <= 1'b0;
        else     match_q <= hit;
    end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 cnt_wr,
    input  logic                 lim_wr,
    input  logic [TT_WORD_W-1:0] wr_data,
    output logic [TT_WORD_W-1:0] cnt_rd_data,
    output logic [TT_WORD_W-1:0] lim_rd_data,
    output logic                 match_pulse
);
    tt_reg_t wr_reg, cnt_reg, lim_reg;
    logic    armed, late, hit;

    assign wr_reg = tt_split(wr_data);

    tt_counter u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .load(cnt_wr), .load_word(wr_reg), .cnt_q(cnt_reg)
    );

    tt_limit u_lim (
        .clk(clk), .rst(rst), .wr(lim_wr), .wr_word(wr_reg),
        .cur_val(cnt_reg.val), .consume(hit),
        .lim_q(lim_reg), .armed(armed), .late(late)
    );

    tt_match u_match (
        .clk(clk), .rst(rst), .tick_en(tick_en), .suppress(lim_wr),
        .armed(armed), .late(late), .cnt_val(cnt_reg.val),
        .lim_val(lim_reg.val), .hit(hit), .match_q(match_pulse)
    );

    assign cnt_rd_data = tt_join(cnt_reg);
    assign lim_rd_data = tt_join(lim_reg);
endmodule

// File: rtl/tt_checker.sv
module tt_checker
    import tick_timer_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_en,
    input logic                 cnt_wr,
    input logic                 lim_wr,
    input logic [TT_WORD_W-1:0] wr_data,
    input logic [TT_WORD_W-1:0] cnt_rd_data,
    input logic [TT_WORD_W-1:0] lim_rd_data,
    input logic                 match_pulse
);
    p_count_load_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_rd_data == $past(wr_data));

    p_limit_load_r3: assert property (@(posedge clk) disable iff (rst)
        lim_wr |=> lim_rd_data == $past(wr_data));

    p_zero_limit_r4: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> lim_rd_data[TT_VAL_W-1:0] != '0);

    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> !lim_rd_data[TT_WORD_W-1]);

    p_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> $past(tick_en));

    p_single_r9: assert property (@(posedge clk) disable iff (rst)
        match_pulse |=> !match_pulse);

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (cnt_rd_data[TT_WORD_W-1] && lim_rd_data[TT_WORD_W-1] && !match_pulse));

    p_step_r10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && tick_en) |=>
            cnt_rd_data[TT_VAL_W-1:0] == tt_incr($past(cnt_rd_data[TT_VAL_W-1:0])));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && !tick_en) |=> $stable(cnt_rd_data));
endmodule

bind tick_cmp_timer tt_checker i_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
    .wr_data(wr_data), .cnt_rd_data(cnt_rd_data), .lim_rd_data(lim_rd_data),
    .match_pulse(match_pulse)
);

// File: tb/test_tick_cmp_timer.sv
module test_tick_cmp_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        cnt_wr = 1'b0;
    logic        lim_wr = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] cnt_rd_data, lim_rd_data;
    logic        match_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state, built from the requirements
    logic [62:0] m_cnt, m_lim;
    logic        m_npt, m_dis, m_arm, m_late, m_match;

    always #4 clk = ~clk;

    tick_cmp_timer i_tick_cmp_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_wr(cnt_wr), .lim_wr(lim_wr),
        .wr_data(wr_data), .cnt_rd_data(cnt_rd_data), .lim_rd_data(lim_rd_data),
        .match_pulse(match_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [62:0] inc63(input logic [62:0] v);
        return v + 63'd1;
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_lim = '0; m_npt = 1'b1; m_dis = 1'b1;
        m_arm = 1'b0; m_late = 1'b0; m_match = 1'b0;
    endtask

    task automatic model_step(input bit cw, input bit lw, input logic [63:0] d, input bit en);
        logic [62:0] old_cnt;
        old_cnt = m_cnt;
        m_match = 1'b0;
        if (lw) begin
            m_lim  = d[62:0];
            m_dis  = d[63];
            m_arm  = !d[63] && (d[62:0] != '0);
            m_late = (d[62:0] <= old_cnt);
        end else if (en && m_arm && (m_late || inc63(old_cnt) == m_lim)) begin
            m_match = 1'b1;
            m_arm   = 1'b0;
        end
        if (cw) begin
            m_cnt = d[62:0];
            m_npt = d[63];
        end else if (en) begin
            m_cnt = inc63(old_cnt);
        end
    endtask

    task automatic compare_all(input string req);
        check({req, " count"}, cnt_rd_data, {m_npt, m_cnt});
        check({req, " limit"}, lim_rd_data, {m_dis, m_lim});
        check({req, " match"}, {63'd0, match_pulse}, {63'd0, m_match});
    endtask

    // drive at a falling edge, update model at the rising edge, check at the next falling edge
    task automatic step(input string req, input bit cw, input bit lw,
                        input logic [63:0] d, input bit en);
        cnt_wr = cw; lim_wr = lw; wr_data = d; tick_en = en;
        @(posedge clk);
        model_step(cw, lw, d, en);
        @(negedge clk);
        cnt_wr = 1'b0; lim_wr = 1'b0; tick_en = 1'b0;
        compare_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check("R8 count after reset", cnt_rd_data, 64'h8000_0000_0000_0000);
        check("R8 limit after reset", lim_rd_data, 64'h8000_0000_0000_0000);
        check("R8 match after reset", {63'd0, match_pulse}, 64'd0);

        // R1 / R2 count write and flag readback
        step("R1 load", 1, 0, 64'h0000_0000_0000_0010, 0);
        check("R1 count value", cnt_rd_data, 64'h0000_0000_0000_0010);
        step("R2 flag", 1, 0, 64'h8000_0000_0000_0005, 0);
        check("R2 flag readback", cnt_rd_data, 64'h8000_0000_0000_0005);
        // R10 count write beats a tick
        step("R10 priority", 1, 0, 64'h0000_0000_0000_0040, 1);
        check("R10 write over tick", cnt_rd_data, 64'h0000_0000_0000_0040);

        // R10 wrap at 2^63
        step("R10 wrap", 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 0);
        step("R10 wrap", 0, 0, 64'd0, 1);
        check("R10 wrapped to zero", cnt_rd_data, 64'd0);

        // R5 disabled limit, R3 readback
        step("R5 setup", 0, 1, 64'h8000_0000_0000_0003, 0);
        check("R3 limit readback", lim_rd_data, 64'h8000_0000_0000_0003);
        for (int i = 0; i < 6; i++) step("R5 disabled", 0, 0, 64'd0, 1);

        // R4 zero limit
        step("R4 setup", 1, 0, 64'd0, 0);
        step("R4 setup", 0, 1, 64'd0, 0);
        for (int i = 0; i < 4; i++) step("R4 zero", 0, 0, 64'd0, 1);

        // R6 normal match after five ticks, then R9 silence
        step("R6 setup", 1, 0, 64'd0, 0);
        step("R6 setup", 0, 1, 64'd5, 0);
        for (int i = 0; i < 4; i++) begin
            step("R6 before", 0, 0, 64'd0, 1);
            check("R6 no early match", {63'd0, match_pulse}, 64'd0);
        end
        step("R6 hit", 0, 0, 64'd0, 1);
        check("R6 match on fifth tick", {63'd0, match_pulse}, 64'd1);
        step("R9 idle", 0, 0, 64'd0, 0);
        check("R9 pulse one cycle", {63'd0, match_pulse}, 64'd0);
        step("R9 rewind", 1, 0, 64'd0, 0);
        for (int i = 0; i < 8; i++) begin
            step("R9 no rearm", 0, 0, 64'd0, 1);
            check("R9 single match", {63'd0, match_pulse}, 64'd0);
        end

        // R7 limit already behind fires on next tick
        step("R7 setup", 1, 0, 64'd100, 0);
        step("R7 setup", 0, 1, 64'd50, 0);
        step("R7 idle", 0, 0, 64'd0, 0);
        check("R7 no match without tick", {63'd0, match_pulse}, 64'd0);
        step("R7 tick", 0, 0, 64'd0, 1);
        check("R7 late fires", {63'd0, match_pulse}, 64'd1);
        // R7 equal to count at write time
        step("R7 equal", 0, 1, 64'd101, 0);
        step("R7 equal tick", 0, 0, 64'd0, 1);
        check("R7 equal fires", {63'd0, match_pulse}, 64'd1);

        // R10 limit write beats a tick-time match
        step("R10 setup", 0, 1, 64'd103, 0);
        step("R10 lw over match", 0, 1, 64'd103, 1);
        check("R10 no match on write", {63'd0, match_pulse}, 64'd0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [63:0] d;
            bit cw, lw, en;
            r  = $urandom;
            en = (r[1:0] != 2'd0);
            cw = (r[6:3] == 4'd0);
            lw = !cw && (r[10:7] < 4'd2);
            d  = {$urandom, $urandom};
            if (lw) begin
                case (r[13:11])
                    3'd0:    d = {1'b0, 63'd0};
                    3'd1:    d = {1'b1, m_cnt + 63'(r[17:14])};
                    3'd2:    d = {1'b0, m_cnt - 63'(r[17:14])};
                    default: d = {1'b0, m_cnt + 63'(r[17:14])};
                endcase
            end else if (cw && r[20]) begin
                d = {r[21], 63'h7FFF_FFFF_FFFF_FFF0 + 63'(r[25:22])};
            end
            step("R6 R9 R10 random", cw, lw, d, en);
        end

        // R8 reset mid-run cancels an armed compare
        step("R8 setup", 1, 0, 64'd0, 0);
        step("R8 setup", 0, 1, 64'd2, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare_all("R8 mid reset");
        for (int i = 0; i < 4; i++) step("R8 cancelled", 0, 0, 64'd0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule